// File: doc/BRIEF.md
# Prefetching Fall-Through FIFO

A single-clock FIFO built on a storage array whose read port is registered: a word leaves the array one clock after its address is applied. The controller hides that latency. It always addresses the word at the head of the queue, so the head is already on `data_o` before the consumer asks for it. A read pulse accepts that word, and the read address moves to the next slot combinationally in the same cycle. Successive reads therefore present a new word on every clock.

A word written into an empty FIFO falls through to the output on a clock edge. No read pulse is needed for this. The FIFO also offers an optional hold output. In that mode the last word taken by a read stays visible until the next read pulse, and during a read pulse the output shows the prefetched head.

The depth is a power-of-two parameter greater than one, and the width is also a parameter (36 bits by default). Pointers carry one wrap bit above the address.

Top module: `pf_fifo`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `empty_o` is 1 and `full_o` is 0; in hold mode `data_o` is 0 until the first accepted read.
- R2: A word written into an empty FIFO on rising edge N is shown on `data_o`, with `empty_o` low, after edge N+1, with `rd_i` held low throughout.
- R3: A read is accepted when `rd_i` is 1 and `empty_o` is 0. After that edge `data_o` carries the next word in write order. If that word was written at least one edge earlier, reads held high give one new word per clock.
- R4: If the next word was written on the same edge as the read that exposes it, or not at all, `empty_o` is 1 after that edge. It stays 1 until one edge has passed since the write.
- R5: `full_o` is 1 exactly when DEPTH words are stored. A write while `full_o` is 1 is dropped, and the dropped word never appears at the output.
- R6: `rd_i` while `empty_o` is 1 has no effect: the following words are returned from the same position.
- R7: Words leave in the order they were written, none lost or repeated. An accepted read and an accepted write in the same cycle leave the stored count unchanged.
- R8: In hold mode (`OUT_MODE` = `OUT_HOLD`), `data_o` shows the head word during an accepted read. At all other times it shows the word taken by the most recent accepted read.
- R9: In pass mode (`OUT_MODE` = `OUT_PASS`), while `empty_o` is 0 and `rd_i` is 0, the next edge leaves `empty_o` at 0 and `data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Common clock for both sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Word to store |
| full_o | output | 1 | DEPTH words stored |
| rd_i | input | 1 | Read acknowledge for the word on `data_o` |
| data_o | output | DATA_W | Head word (pass) or held/prefetched word (hold) |
| empty_o | output | 1 | No word ready at the output |

## Verification
The assertions assume that `rd_i` and `wr_i` are known values at every rising edge after reset, and that `rd_i` is low during the first edge after reset, so that the hold-mode past-value checks start from a defined read. The bench changes inputs only at falling edges and keeps both requests low while reset is applied. During random traffic it drives writes into a full FIFO and reads from an empty one, because the assertions treat those requests as legal and dropped rather than forbidden.

// File: rtl/pf_fifo_pkg.sv
package pf_fifo_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic {
    OUT_PASS = 1'b0,  // data_o follows the prefetched head
    OUT_HOLD = 1'b1   // data_o keeps the last accepted word between reads
  } out_mode_e;

  function automatic bit is_pow2(int unsigned v);
    return (v > 1) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/pf_fifo_ram.sv
module pf_fifo_ram #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // read port always enabled; same-address write returns the old word
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pf_fifo_ptrs.sv
module pf_fifo_ptrs #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_acc_i,
  output logic             wr_acc_o,
  output logic             full_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] fetch_ptr_o,
  output logic             fetch_valid_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

  assign full_o = (wr_ptr_q[ADDR_W-1:0] == rd_ptr_q[ADDR_W-1:0]) &&
                  (wr_ptr_q[ADDR_W] != rd_ptr_q[ADDR_W]);
  assign wr_acc_o = wr_i & ~full_o;

  // next head address chosen in the same cycle as the read
  assign fetch_ptr_o   = rd_acc_i ? rd_ptr_q + PTR_W'(1) : rd_ptr_q;
  // the word at fetch_ptr is readable only if written on an earlier edge
  assign fetch_valid_o = (fetch_ptr_o != wr_ptr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_acc_o) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      rd_ptr_q <= fetch_ptr_o;
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
endmodule

// File: rtl/pf_fifo_out.sv
module pf_fifo_out
  import pf_fifo_pkg::*;
#(
  parameter int unsigned DATA_W   = 36,
  parameter out_mode_e   OUT_MODE = OUT_PASS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic              rd_acc_i,
  input  logic [DATA_W-1:0] ram_q_i,
  output logic              head_valid_o,
  output logic [DATA_W-1:0] data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic head_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) head_valid_q <= 1'b0;
    else         head_valid_q <= fetch_valid_i;
  end
  assign head_valid_o = head_valid_q;

  if (OUT_MODE == OUT_HOLD) begin : g_hold
    logic [DATA_W-1:0] hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       hold_q <= '0;
      else if (rd_acc_i) hold_q <= ram_q_i;
    end
    assign data_o = rd_acc_i ? ram_q_i : hold_q;
  end else begin : g_pass
    logic unused_rd;
    assign unused_rd = rd_acc_i;
    assign data_o    = ram_q_i;
  end
endmodule

// File: rtl/pf_fifo.sv
module pf_fifo
  import pf_fifo_pkg::*;
#(
  parameter int unsigned DATA_W   = 36,
  parameter int unsigned DEPTH    = 64,
  parameter out_mode_e   OUT_MODE = OUT_PASS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned PTR_W  = ADDR_W + 1;

  if (!is_pow2(DEPTH)) begin : g_bad_depth
    $fatal(1, "pf_fifo: DEPTH must be a power of two above 1");
  end

  logic             head_valid, rd_acc, wr_acc, fetch_valid;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, fetch_ptr;
  logic [DATA_W-1:0] ram_q;

  assign rd_acc  = rd_i & head_valid;
  assign empty_o = ~head_valid;

  pf_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_i),
    .rd_acc_i      (rd_acc),
    .wr_acc_o      (wr_acc),
    .full_o        (full_o),
    .wr_ptr_o      (wr_ptr),
    .rd_ptr_o      (rd_ptr),
    .fetch_ptr_o   (fetch_ptr),
    .fetch_valid_o (fetch_valid)
  );

  pf_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_acc),
    .waddr_i (wr_ptr[ADDR_W-1:0]),
    .wdata_i (wdata_i),
    .raddr_i (fetch_ptr[ADDR_W-1:0]),
    .rdata_o (ram_q)
  );

  pf_fifo_out #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE)) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid),
    .rd_acc_i      (rd_acc),
    .ram_q_i       (ram_q),
    .head_valid_o  (head_valid),
    .data_o        (data_o)
  );
endmodule

// File: rtl/pf_fifo_chk.sv
module pf_fifo_chk
  import pf_fifo_pkg::*;
#(
  parameter int unsigned DATA_W   = 36,
  parameter int unsigned DEPTH    = 64,
  parameter out_mode_e   OUT_MODE = OUT_PASS,
  localparam int unsigned PTR_W   = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              full_o,
  input logic              empty_o,
  input logic [DATA_W-1:0] data_o,
  input logic [PTR_W-1:0]  wr_ptr_i,
  input logic [PTR_W-1:0]  rd_ptr_i
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [PTR_W-1:0] occ;
  assign occ = wr_ptr_i - rd_ptr_i;

  // R5
  full_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o);

  // R5
  wr_full_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !(rd_i && !empty_o) |=> $stable(wr_ptr_i) && full_o);

  // R6
  rd_empty_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_i |=> $stable(rd_ptr_i));

  // R7
  occ_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !full_o && rd_i && !empty_o |=> occ == $past(occ));

  // R7
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= PTR_W'(DEPTH));

  if (OUT_MODE == OUT_HOLD) begin : g_hold_chk
    // R8
    hold_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rd_i && !empty_o) && !rd_i |-> data_o == $past(data_o));
  end else begin : g_pass_chk
    // R9
    head_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !empty_o && !rd_i |=> !empty_o && $stable(data_o));
  end
endmodule

bind pf_fifo pf_fifo_chk #(
  .DATA_W   (DATA_W),
  .DEPTH    (DEPTH),
  .OUT_MODE (OUT_MODE)
) u_pf_fifo_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .data_o   (data_o),
  .wr_ptr_i (wr_ptr),
  .rd_ptr_i (rd_ptr)
);

// File: tb/pf_fifo_bench.sv
module pf_fifo_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DATA_W = 36;
  localparam int DEPTH  = 64;
  localparam int NSTEP  = 16;

  // {wr, rd, wdata[7:0], exp_empty, exp_data[7:0]}; state seen before the edge
  localparam logic [18:0] STEPS [NSTEP] = '{
    {1'b1, 1'b0, 8'hA1, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h00},
    {1'b1, 1'b0, 8'hA2, 1'b0, 8'hA1},
    {1'b1, 1'b1, 8'hA3, 1'b0, 8'hA1},
    {1'b0, 1'b1, 8'h00, 1'b0, 8'hA2},
    {1'b0, 1'b1, 8'h00, 1'b0, 8'hA3},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'h00},
    {1'b1, 1'b1, 8'hA4, 1'b1, 8'h00},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'h00},
    {1'b1, 1'b1, 8'hA5, 1'b0, 8'hA4},
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h00},
    {1'b1, 1'b0, 8'hA6, 1'b0, 8'hA5},
    {1'b1, 1'b1, 8'hA7, 1'b0, 8'hA5},
    {1'b0, 1'b1, 8'h00, 1'b0, 8'hA6},
    {1'b0, 1'b1, 8'h00, 1'b0, 8'hA7},
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h00}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0, rd_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              full_o, empty_o, h_full, h_empty;
  logic [DATA_W-1:0] data_o, h_data;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  pf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pf_fifo (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .full_o, .rd_i, .data_o, .empty_o
  );

  pf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OUT_MODE(pf_fifo_pkg::OUT_HOLD)) u_pf_fifo_hold (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .full_o(h_full), .rd_i, .data_o(h_data), .empty_o(h_empty)
  );

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at the falling edge, then settle; caller observes pre-edge state
  task automatic step(input logic w, input logic r, input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    wr_i = w; rd_i = r; wdata_i = d;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0; rst_ni = 1'b0;
    #1;
    chk(empty_o === 1'b1, "R1 empty in reset", DATA_W'(empty_o), 1);
    chk(full_o === 1'b0, "R1 full in reset", DATA_W'(full_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
  endtask

  initial begin
    logic [DATA_W-1:0] mdl[$];
    logic [DATA_W-1:0] last_pop, prev_data;
    logic              prev_hold;

    repeat (3) @(negedge clk_i);
    do_reset();
    chk(empty_o === 1'b1 && full_o === 1'b0, "R1 flags after reset",
        DATA_W'({full_o, empty_o}), 1);
    chk(h_data === '0, "R1 hold zero after reset", h_data, 0);

    // vector table: R2 fall-through, R3 advance, R4 bubbles
    for (int i = 0; i < NSTEP; i++) begin
      step(STEPS[i][18], STEPS[i][17], DATA_W'(STEPS[i][16:9]));
      chk(empty_o === STEPS[i][8], $sformatf("R4 empty step %0d", i),
          DATA_W'(empty_o), DATA_W'(STEPS[i][8]));
      if (!STEPS[i][8])
        chk(data_o === DATA_W'(STEPS[i][7:0]), $sformatf("R3 data step %0d", i),
            data_o, DATA_W'(STEPS[i][7:0]));
    end

    // R2 and R8: fall-through without a read, hold output behaviour
    do_reset();
    step(1'b1, 1'b0, 36'h0_1111_0001);
    step(1'b0, 1'b0, '0);
    chk(empty_o === 1'b1, "R2 one edge not enough", DATA_W'(empty_o), 1);
    step(1'b1, 1'b0, 36'h0_2222_0002);
    chk(empty_o === 1'b0 && data_o === 36'h0_1111_0001, "R2 fall-through",
        data_o, 36'h0_1111_0001);
    chk(h_data === '0, "R8 hold before any read", h_data, 0);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b1, '0);
    chk(h_data === 36'h0_1111_0001, "R8 head during read", h_data, 36'h0_1111_0001);
    step(1'b0, 1'b0, '0);
    chk(h_data === 36'h0_1111_0001, "R8 held after read", h_data, 36'h0_1111_0001);
    chk(data_o === 36'h0_2222_0002, "R3 pass shows next", data_o, 36'h0_2222_0002);

    // R5: fill, drop overflow, drain at full rate
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DATA_W'(100 + i));
    step(1'b1, 1'b0, DATA_W'(999));
    chk(full_o === 1'b1, "R5 full at DEPTH", DATA_W'(full_o), 1);
    step(1'b0, 1'b0, '0);
    chk(full_o === 1'b1, "R5 full after dropped write", DATA_W'(full_o), 1);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 1'b1, '0);
      chk(empty_o === 1'b0 && data_o === DATA_W'(100 + i), "R3 back-to-back drain",
          data_o, DATA_W'(100 + i));
    end
    step(1'b0, 1'b0, '0);
    chk(empty_o === 1'b1 && full_o === 1'b0, "R5 dropped word absent",
        DATA_W'({full_o, empty_o}), 1);

    // R6: reads on empty are ignored
    do_reset();
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    step(1'b1, 1'b0, DATA_W'(55));
    step(1'b1, 1'b0, DATA_W'(56));
    step(1'b0, 1'b1, '0);
    chk(empty_o === 1'b0 && data_o === DATA_W'(55), "R6 first word kept", data_o, DATA_W'(55));
    step(1'b0, 1'b0, '0);
    chk(empty_o === 1'b0 && data_o === DATA_W'(56), "R6 second word kept", data_o, DATA_W'(56));

    // R7 random traffic against a queue model, plus R8 and R9 tracking
    do_reset();
    last_pop = '0; prev_hold = 1'b0; prev_data = '0;
    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < 1000; c++) begin
        logic w, r;
        logic [DATA_W-1:0] d;
        w = (($urandom % 8) < ((ph == 1) ? 7 : (ph == 2) ? 2 : 4));
        r = (($urandom % 8) < ((ph == 1) ? 2 : (ph == 2) ? 7 : 4));
        d = {$urandom, $urandom};
        step(w, r, d);
        chk(full_o === (mdl.size() == DEPTH), "R5 full vs model",
            DATA_W'(full_o), DATA_W'(mdl.size() == DEPTH));
        chk(empty_o === 1'b1 || mdl.size() > 0, "R4 never shows absent word",
            DATA_W'(empty_o), 1);
        if (prev_hold)
          chk(empty_o === 1'b0 && data_o === prev_data, "R9 head stable",
              data_o, prev_data);
        if (r && !empty_o) begin
          chk(data_o === mdl[0], "R7 order", data_o, mdl[0]);
          chk(h_data === mdl[0], "R8 head during read", h_data, mdl[0]);
          last_pop = mdl.pop_front();
        end else begin
          chk(h_data === last_pop, "R8 hold value", h_data, last_pop);
        end
        if (w && !full_o) mdl.push_back(d);
        prev_hold = !empty_o && !r;
        prev_data = data_o;
      end
    end

    // R1: reset mid-traffic clears state
    step(1'b1, 1'b0, DATA_W'(7));
    step(1'b1, 1'b0, DATA_W'(8));
    do_reset();
    chk(empty_o === 1'b1 && full_o === 1'b0, "R1 reset clears",
        DATA_W'({full_o, empty_o}), 1);
    chk(h_data === '0, "R1 hold cleared", h_data, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule